// File: doc/BRIEF.md
# Lockable Protection Configuration Byte Store

This block keeps the 8-bit configuration bytes of a bank of physical memory protection entries. Software writes them as packed words through a register-style port. Each word carries four bytes on a 32-bit machine and eight bytes on a 64-bit machine. The block does not simply accept every byte. For each byte it decides whether the write may land, based on three things:

- the entry's current lock bit;
- three security control bits that arrive as inputs: a rule-lock bypass, a machine-mode lockdown and a machine-mode whitelist;
- for lockdown, the content of the new byte itself.

A byte that is refused keeps its old value. Each refusal is reported on a registered, single-cycle error flag together with the refused entries.

All stored bytes are exposed together on one flat output bus, which feeds a permission checker elsewhere. The block does not hold address registers, does not decode ranges and does not decode the security register. A build parameter selects whether the enhanced security behaviour is present. Without it, the three security bits have no effect on anything.

Top module: `pmp_cfg_regfile`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, every configuration byte reads zero (all entries off and unlocked), and the error outputs are low.
- R2: Byte layout is R at bit 0, W at bit 1, X at bit 2, match mode at bits 4:3 and lock L at bit 7. A write to word index `i` offers byte `k` (data bits 8k+7:8k) to entry 4i+k, for k below XLEN/8. Entry `e` appears on `cfg_flat` bits 8e+7:8e. Lanes that map past the last entry are dropped silently.
- R3: Built without the enhanced behaviour, a byte is stored only when the entry's current L bit is clear. The three security inputs change nothing.
- R4: Built with the enhanced behaviour, while `sec_bypass` is high every offered byte is stored, whatever the entry's lock state.
- R5: Enhanced, with bypass and lockdown both low, a byte is stored only when the entry's current L bit is clear.
- R6: Enhanced, with lockdown high and bypass low, the stored lock bit is not consulted. A new byte with L=1 is stored only if its X is 0. A new byte with L=0 is stored unless its bits 2:0 equal 3'b110.
- R7: A refused byte keeps its previous value. Each byte of one word is decided independently.
- R8: With XLEN=64, a write to an odd word index is discarded whole and sets `rej_odd`, unless the block is enhanced and `sec_bypass` is high. In that case the word is applied with the same 4i+k mapping.
- R9: After the clock edge that takes a write, for exactly the following cycle:
  - `rej_pulse` is high if any byte was refused or the word was discarded;
  - `rej_mask` marks the refused entries;
  - `rej_idx` gives the lowest refused entry, or 0 if none was refused.

  All of these are low or zero after a cycle without a write.
- R10: `sec_whitelist` has no influence on whether any byte is stored or refused.
- R11: A cycle with `wr_en` low leaves every stored byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Packed configuration write strobe |
| wr_idx | input | IDX_W | Configuration word index |
| wr_data | input | XLEN | Packed configuration bytes |
| sec_bypass | input | 1 | Rule-lock bypass control bit |
| sec_lockdown | input | 1 | Machine-mode lockdown control bit |
| sec_whitelist | input | 1 | Machine-mode whitelist control bit (no write effect) |
| cfg_flat | output | NUM_ENTRIES*8 | All stored configuration bytes |
| rej_pulse | output | 1 | One-cycle error flag for a refused write |
| rej_odd | output | 1 | Whole word discarded for an odd index |
| rej_mask | output | NUM_ENTRIES | Entries refused by the last write |
| rej_idx | output | ENT_W | Lowest refused entry |

## Verification
The bench builds two copies side by side and drives them with the same stimulus.

The first copy uses the defaults: 16 entries, XLEN=64, enhanced. It exercises:
- odd-index discard;
- the bypass rescue of index 3, whose upper four lanes fall past the last entry;
- every branch of the lockdown content rule.

The second copy is XLEN=32 and not enhanced. In it, odd indices are ordinary words, and the bypass, lockdown and whitelist inputs must change nothing. A behavioural model for each copy is compared every cycle, under directed corner writes and then a long random mix.

// File: rtl/pmp_cfg_pkg.sv
`timescale 1ns/1ps
package pmp_cfg_pkg;

  // Configuration byte layout (R2): lock at 7, match mode at 4:3, X/W/R at 2:0
  typedef struct packed {
    logic       lock;
    logic [1:0] rsv;
    logic [1:0] amode;
    logic       x;
    logic       w;
    logic       r;
  } cfg_byte_t;

  typedef struct packed {
    logic bypass;
    logic lockdown;
    logic whitelist;
  } sec_ctl_t;

  // Per-byte write policy (R3..R6); whitelist deliberately unused (R10)
  function automatic logic cfg_write_allowed(input logic enh, input sec_ctl_t s,
                                             input cfg_byte_t cur, input cfg_byte_t nxt);
    logic ok;
    if (!enh)                 ok = !cur.lock;
    else if (s.bypass)        ok = 1'b1;
    else if (!s.lockdown)     ok = !cur.lock;
    else if (nxt.lock)        ok = !nxt.x;
    else                      ok = ({nxt.x, nxt.w, nxt.r} != 3'b110);
    return ok;
  endfunction

  // Whole-word discard for odd index on 64-bit builds (R8)
  function automatic logic odd_word_dropped(input int xlen, input logic enh,
                                            input logic bypass, input logic idx_lsb);
    return (xlen == 64) && idx_lsb && !(enh && bypass);
  endfunction

  // Lane of the packed word that feeds a given entry (R2); may be out of range
  function automatic int lane_of(input int entry, input int idx);
    return entry - 4 * idx;
  endfunction

endpackage

// File: rtl/pmp_cfg_word_router.sv
`timescale 1ns/1ps
module pmp_cfg_word_router
  import pmp_cfg_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 64,
  parameter bit ENHANCED    = 1'b1,
  parameter int IDX_W       = 2
) (
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [XLEN-1:0]          wr_data,
  input  logic                     bypass,
  output logic [NUM_ENTRIES-1:0]   hit_vec,
  output logic [NUM_ENTRIES*8-1:0] wbyte_flat,
  output logic                     word_drop
);

  localparam int BPW = XLEN / 8;

  assign word_drop = wr_en && odd_word_dropped(XLEN, ENHANCED, bypass, wr_idx[0]);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_lane
    int              lane;
    logic            hit_l;
    logic [XLEN-1:0] shifted;

    always_comb begin
      lane = lane_of(e, int'(wr_idx));
      if (lane >= 0 && lane < BPW) begin
        hit_l   = wr_en && !word_drop;
        shifted = wr_data >> (8 * lane);
      end else begin
        hit_l   = 1'b0;
        shifted = '0;
      end
    end

    assign hit_vec[e]           = hit_l;
    assign wbyte_flat[e*8 +: 8] = shifted[7:0];
  end

endmodule

// File: rtl/pmp_cfg_entry.sv
`timescale 1ns/1ps
module pmp_cfg_entry
  import pmp_cfg_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit,
  input  cfg_byte_t wbyte,
  input  sec_ctl_t  sec,
  output cfg_byte_t cfg_q,
  output logic      reject
);

  logic ok;

  assign ok     = cfg_write_allowed(ENHANCED, sec, cfg_q, wbyte);
  assign reject = wr_hit && !ok;

  // R1 reset clear, R7 refused byte keeps its value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cfg_q <= '0;
    else if (wr_hit && ok)  cfg_q <= wbyte;
  end

endmodule

// File: rtl/pmp_reject_encoder.sv
`timescale 1ns/1ps
module pmp_reject_encoder #(
  parameter int NUM_ENTRIES = 16,
  parameter int ENT_W       = 4
) (
  input  logic [NUM_ENTRIES-1:0] mask,
  output logic                   any,
  output logic [ENT_W-1:0]       idx
);

  assign any = |mask;

  // Lowest set entry wins (R9)
  always_comb begin
    idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (mask[i]) idx = ENT_W'(i);
    end
  end

endmodule

// File: rtl/pmp_cfg_regfile.sv
`timescale 1ns/1ps
module pmp_cfg_regfile
  import pmp_cfg_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 64,
  parameter bit ENHANCED    = 1'b1,
  localparam int IDX_W      = $clog2(NUM_ENTRIES / 4),
  localparam int ENT_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [XLEN-1:0]          wr_data,
  input  logic                     sec_bypass,
  input  logic                     sec_lockdown,
  input  logic                     sec_whitelist,
  output logic [NUM_ENTRIES*8-1:0] cfg_flat,
  output logic                     rej_pulse,
  output logic                     rej_odd,
  output logic [NUM_ENTRIES-1:0]   rej_mask,
  output logic [ENT_W-1:0]         rej_idx
);

  sec_ctl_t                 sec;
  logic [NUM_ENTRIES-1:0]   hit_vec;
  logic [NUM_ENTRIES-1:0]   reject_vec;
  logic [NUM_ENTRIES*8-1:0] wbyte_flat;
  logic                     word_drop;
  logic                     enc_any;
  logic [ENT_W-1:0]         enc_idx;

  assign sec = '{bypass: sec_bypass, lockdown: sec_lockdown, whitelist: sec_whitelist};

  pmp_cfg_word_router #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .XLEN        (XLEN),
    .ENHANCED    (ENHANCED),
    .IDX_W       (IDX_W)
  ) u_router (
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .bypass     (sec_bypass),
    .hit_vec    (hit_vec),
    .wbyte_flat (wbyte_flat),
    .word_drop  (word_drop)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    pmp_cfg_entry #(.ENHANCED(ENHANCED)) u_entry (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (hit_vec[e]),
      .wbyte  (wbyte_flat[e*8 +: 8]),
      .sec    (sec),
      .cfg_q  (cfg_flat[e*8 +: 8]),
      .reject (reject_vec[e])
    );
  end

  pmp_reject_encoder #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ENT_W       (ENT_W)
  ) u_enc (
    .mask (reject_vec),
    .any  (enc_any),
    .idx  (enc_idx)
  );

  // Registered single-cycle error report (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_pulse <= 1'b0;
      rej_odd   <= 1'b0;
      rej_mask  <= '0;
      rej_idx   <= '0;
    end else begin
      rej_pulse <= enc_any || word_drop;
      rej_odd   <= word_drop;
      rej_mask  <= reject_vec;
      rej_idx   <= enc_idx;
    end
  end

endmodule

// File: rtl/pmp_cfg_regfile_chk.sv
`timescale 1ns/1ps
module pmp_cfg_regfile_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 64,
  parameter bit ENHANCED    = 1'b1,
  localparam int IDX_W      = $clog2(NUM_ENTRIES / 4),
  localparam int ENT_W      = $clog2(NUM_ENTRIES)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [IDX_W-1:0]         wr_idx,
  input logic                     sec_bypass,
  input logic                     sec_lockdown,
  input logic [NUM_ENTRIES*8-1:0] cfg_flat,
  input logic                     rej_pulse,
  input logic                     rej_odd,
  input logic [NUM_ENTRIES-1:0]   rej_mask,
  input logic [ENT_W-1:0]         rej_idx,
  input logic [NUM_ENTRIES-1:0]   hit_vec,
  input logic [NUM_ENTRIES-1:0]   reject_vec,
  input logic [NUM_ENTRIES*8-1:0] wbyte_flat
);

  localparam logic [NUM_ENTRIES-1:0] ONE = NUM_ENTRIES'(1);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_flat == '0 && !rej_pulse));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_flat));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!rej_pulse && !rej_odd && rej_mask == '0));

  p_pulse_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|reject_vec) |=> (rej_pulse && rej_mask == $past(reject_vec)));

  p_lowest_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rej_mask) |-> (rej_mask[rej_idx] && ((rej_mask & ((ONE << rej_idx) - ONE)) == '0)));

  if (XLEN == 64) begin : g_odd
    p_odd_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx[0] && !(ENHANCED && sec_bypass)) |=> (rej_odd && rej_pulse && $stable(cfg_flat)));
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_e
    // R3 and R5: locked entry without bypass or lockdown holds
    p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec[e] && cfg_flat[e*8+7] && !(ENHANCED && (sec_bypass || sec_lockdown)))
      |=> ($stable(cfg_flat[e*8 +: 8]) && rej_mask[e]));

    p_reject_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reject_vec[e] |=> $stable(cfg_flat[e*8 +: 8]));

    if (ENHANCED) begin : g_enh
      p_bypass_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec[e] && sec_bypass) |=> (cfg_flat[e*8 +: 8] == $past(wbyte_flat[e*8 +: 8])));

      p_ld_private_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec[e] && sec_lockdown && !sec_bypass && wbyte_flat[e*8+7] && !wbyte_flat[e*8+2])
        |=> (cfg_flat[e*8 +: 8] == $past(wbyte_flat[e*8 +: 8])));

      p_ld_shared_wx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec[e] && sec_lockdown && !sec_bypass && !wbyte_flat[e*8+7] &&
         wbyte_flat[e*8 +: 3] == 3'b110)
        |=> ($stable(cfg_flat[e*8 +: 8]) && rej_mask[e]));
    end
  end

endmodule

bind pmp_cfg_regfile pmp_cfg_regfile_chk #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .XLEN        (XLEN),
  .ENHANCED    (ENHANCED)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_idx       (wr_idx),
  .sec_bypass   (sec_bypass),
  .sec_lockdown (sec_lockdown),
  .cfg_flat     (cfg_flat),
  .rej_pulse    (rej_pulse),
  .rej_odd      (rej_odd),
  .rej_mask     (rej_mask),
  .rej_idx      (rej_idx),
  .hit_vec      (hit_vec),
  .reject_vec   (reject_vec),
  .wbyte_flat   (wbyte_flat)
);

// File: tb/pmp_cfg_regfile_bench.sv
`timescale 1ns/1ps
module pmp_cfg_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        byp = 1'b0, lkd = 1'b0, wl = 1'b0;

  wire [127:0] cfg_a, cfg_b;
  wire         pulse_a, odd_a, pulse_b, odd_b;
  wire [15:0]  mask_a, mask_b;
  wire [3:0]   idx_a, idx_b;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  string mreq = "R1";

  // reference state, index 0 = 64-bit enhanced copy, 1 = 32-bit plain copy
  logic [7:0]  mcfg [2][16];
  bit          mpulse [2];
  bit          modd [2];
  logic [15:0] mmask [2];
  int          midx [2];

  always #5 clk = ~clk;

  pmp_cfg_regfile u_pmp_cfg_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sec_bypass(byp), .sec_lockdown(lkd), .sec_whitelist(wl),
    .cfg_flat(cfg_a), .rej_pulse(pulse_a), .rej_odd(odd_a), .rej_mask(mask_a), .rej_idx(idx_a)
  );

  pmp_cfg_regfile #(.NUM_ENTRIES(16), .XLEN(32), .ENHANCED(1'b0)) u_legacy (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data[31:0]),
    .sec_bypass(byp), .sec_lockdown(lkd), .sec_whitelist(wl),
    .cfg_flat(cfg_b), .rej_pulse(pulse_b), .rej_odd(odd_b), .rej_mask(mask_b), .rej_idx(idx_b)
  );

  // policy written from R3..R6 (whitelist absent on purpose, R10)
  function automatic bit may_write(bit enh, bit bp, bit ld, logic [7:0] old_b, logic [7:0] new_b);
    if (!enh) return !old_b[7];
    if (bp)   return 1'b1;
    if (!ld)  return !old_b[7];
    if (new_b[7]) return !new_b[2];
    return new_b[2:0] != 3'b110;
  endfunction

  task automatic model_step(int inst);
    int  bpw = (inst == 0) ? 8 : 4;
    bit  enh = (inst == 0);
    mpulse[inst] = 0; modd[inst] = 0; mmask[inst] = '0; midx[inst] = 0;
    if (wr_en) begin
      if (inst == 0 && wr_idx[0] && !(enh && byp)) begin
        modd[inst] = 1; mpulse[inst] = 1;
      end else begin
        for (int k = 0; k < bpw; k++) begin
          int e = int'(wr_idx) * 4 + k;
          if (e < 16) begin
            if (may_write(enh, byp, lkd, mcfg[inst][e], wr_data[8*k +: 8]))
              mcfg[inst][e] = wr_data[8*k +: 8];
            else begin
              mmask[inst][e] = 1'b1; mpulse[inst] = 1;
            end
          end
        end
      end
    end
    for (int e = 15; e >= 0; e--) if (mmask[inst][e]) midx[inst] = e;
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      for (int e = 0; e < 16; e++) mcfg[i][e] = 8'h00;
      mpulse[i] = 0; modd[i] = 0; mmask[i] = '0; midx[i] = 0;
    end
  end

  always @(posedge clk) begin
    mreq = cur_req;
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        for (int e = 0; e < 16; e++) mcfg[i][e] = 8'h00;
        mpulse[i] = 0; modd[i] = 0; mmask[i] = '0; midx[i] = 0;
      end else model_step(i);
    end
  end

  task automatic check(string what, int inst, logic [127:0] got, logic [127:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s copy%0d %s got %h expected %h", mreq, inst, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      logic [127:0] exp_cfg;
      for (int e = 0; e < 16; e++) exp_cfg[e*8 +: 8] = mcfg[i][e];
      check("cfg_flat", i, (i == 0) ? cfg_a : cfg_b, exp_cfg);
      check("rej_pulse", i, 128'((i == 0) ? pulse_a : pulse_b), 128'(mpulse[i]));
      check("rej_odd", i, 128'((i == 0) ? odd_a : odd_b), 128'(modd[i]));
      check("rej_mask", i, 128'((i == 0) ? mask_a : mask_b), 128'(mmask[i]));
      check("rej_idx", i, 128'((i == 0) ? idx_a : idx_b), 128'(midx[i]));
    end
  end

  task automatic wr(int idx, logic [63:0] d, bit bp, bit ld, bit w, string req);
    @(posedge clk); #1;
    wr_en = 1; wr_idx = 2'(idx); wr_data = d; byp = bp; lkd = ld; wl = w; cur_req = req;
  endtask

  task automatic idle(int n, string req);
    repeat (n) begin
      @(posedge clk); #1;
      wr_en = 0; cur_req = req;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(2, "R1");
    // R2 lane mapping on both copies
    wr(0, 64'h0807_0605_0403_0201, 0, 0, 0, "R2");
    wr(2, 64'h1817_1615_1413_1211, 0, 0, 0, "R2");
    idle(2, "R11");
    // R8 odd index: discarded on 64-bit, ordinary word on 32-bit
    wr(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R8");
    // R3 R5 lock entry 0, then retry; R7 other lanes still land
    wr(0, 64'h0000_0000_0000_0081, 0, 0, 0, "R3 R5");
    wr(0, 64'h0505_0505_0505_0503, 0, 0, 0, "R3 R5 R7");
    wr(0, 64'h0000_0000_0000_0003, 0, 0, 1, "R10");
    idle(1, "R9");
    // R4 bypass overrides lock only on the enhanced copy
    wr(0, 64'h0000_0000_0000_0003, 1, 0, 0, "R4");
    wr(3, 64'hA8A7_A6A5_A4A3_A2A1, 1, 0, 0, "R4 R8");
    wr(1, 64'h0101_0101_0101_0101, 0, 0, 0, "R8");
    wr(1, 64'h0202_0202_0202_0202, 1, 1, 0, "R4 R8");
    // R6 lockdown content rule over locked entries
    wr(0, 64'h8080_8080_8080_8080, 1, 0, 0, "R4");
    wr(0, 64'hC516_8C02_0706_8184, 0, 1, 0, "R6 R7");
    wr(0, 64'h0000_0000_0000_0681, 0, 1, 0, "R9");
    wr(2, 64'h8606_8405_0685_0402, 0, 1, 1, "R6 R10");
    wr(2, 64'h8383_8383_8383_8383, 0, 0, 1, "R5 R10");
    idle(3, "R9 R11");
    // random mix of all policies
    for (int n = 0; n < 400; n++) begin
      @(posedge clk); #1;
      wr_en   = ($urandom() % 4) != 0;
      wr_idx  = 2'($urandom() % 4);
      wr_data = {$urandom(), $urandom()};
      byp     = ($urandom() % 8) == 0;
      lkd     = $urandom() % 2;
      wl      = $urandom() % 2;
      cur_req = "R3 R4 R5 R6 R7 R8 R9 R10 mix";
    end
    idle(4, "R11");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule